// File: doc/BRIEF.md
# Translation Fault Classifier and Exception Vectoring Unit

This block sits behind a page-granular translation lookup. For every memory access it receives the access type, the virtual address, the current and previous program counters, the translation entry (physical page number with readable, writable and fixed flags) and the present Context and EntryHi register values. One cycle later it produces one of two results. On success it gives a physical address and a read or write strobe. On a fault it gives an exception pulse, a cause code, a vector offset, a target PC and write-enable/value pairs for BadVAddr, Context, EntryHi and EPC.

A missing translation comes in two kinds. With the fixed flag clear it is a fast-refill fault sent to the refill vector. With the fixed flag set it is an invalid fault sent to the general vector. A store to a page that is readable but not writable raises a modify fault. That fault records the address but leaves Context and EntryHi alone. Instruction fetches are translated like loads.

Top module: `tfu_fault_unit`

## Requirements
- R1: When `acc_valid` is high on a clock edge, `rsp_valid` is high for exactly the following cycle. A successful access then shows `pa` = {entry page number, `vaddr[11:0]`}. It also shows `mem_rd`=1 for a read-type access or `mem_wr`=1 for a store, with `exc`=0.
- R2: A read-type access (`acc_kind` of 2'b00 load, 2'b10 fetch or 2'b11) with the readable flag clear raises `exc` with `cause`=2. `vec_off` is 12'h180 if the fixed flag is set and 12'h000 if it is clear.
- R3: A store (`acc_kind`=2'b01) with the writable flag clear is handled in this priority order. Readable set gives `cause`=1 and `vec_off`=12'h180. Otherwise fixed set gives `cause`=3 and `vec_off`=12'h180. Otherwise the result is `cause`=3 and `vec_off`=12'h000.
- R4: On a fault `target_pc` equals `VEC_BASE` + `vec_off` (default base 32'h8000_0000). Without a fault `target_pc`, `cause` and `vec_off` are zero.
- R5: Every fault asserts `badv_we` with `badv` equal to the faulting `vaddr`.
- R6: Load-type and store-type faults (cause 2 or 3) assert `ctx_we` with `ctx` = {`ctx_in[31:23]`, `vaddr[31:13]`, 4'b0000}. A modify fault keeps `ctx_we` low.
- R7: Cause 2 or 3 faults assert `ehi_we` with `ehi` = {`vaddr[31:13]`, 5'b00000, `ehi_in[7:0]`}. A modify fault keeps `ehi_we` low.
- R8: Every fault asserts `epc_we` with `epc` equal to `prev_pc`. The value of `cur_pc` has no effect on it.
- R9: During a fault cycle `mem_rd`, `mem_wr` and `pa` are zero and `ld_data` is zero whatever `mem_rdata` holds. On a successful read `ld_data` passes `mem_rdata`.
- R10: In a cycle that follows no request, `rsp_valid`, `exc`, every write enable and both strobes are low.
- R11: A fetch with given flags gives the same cause, vector and register updates as a load with the same flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_kind | input | 2 | 01 store, 00 load, 10 fetch, 11 read-type |
| vaddr | input | 32 | Virtual address |
| cur_pc | input | 32 | PC of the current instruction |
| prev_pc | input | 32 | PC to back up to on a fault |
| ent_ppn | input | 20 | Physical page number from the entry |
| ent_rd | input | 1 | Entry readable flag |
| ent_wr | input | 1 | Entry writable flag |
| ent_fix | input | 1 | Entry fixed flag |
| ctx_in | input | 32 | Current Context register |
| ehi_in | input | 32 | Current EntryHi register |
| mem_rdata | input | 32 | Data returned by memory for the response cycle |
| rsp_valid | output | 1 | Result of the previous cycle's request |
| pa | output | 32 | Physical address on success |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| ld_data | output | 32 | Load data, zero on fault |
| exc | output | 1 | Exception pulse |
| cause | output | 5 | Exception cause code |
| vec_off | output | 12 | Vector offset |
| target_pc | output | 32 | Exception target PC |
| badv_we | output | 1 | BadVAddr write enable |
| badv | output | 32 | BadVAddr value |
| ctx_we | output | 1 | Context write enable |
| ctx | output | 32 | Context value |
| ehi_we | output | 1 | EntryHi write enable |
| ehi | output | 32 | EntryHi value |
| epc_we | output | 1 | EPC write enable |
| epc | output | 32 | EPC value |

## Verification
The bench targets the store case where the page is readable and writable-clear with the fixed flag also set. A design that checked the fixed flag before the readable flag would report a store-invalid fault there and clobber Context and EntryHi. It also goes after the split between refill and invalid faults. A design that got that wrong would send a fixed-flag miss to offset 0 or a refill to 0x180. Fetches are mixed with loads to catch a fetch that is wrongly classed as a store. The bench drives `cur_pc` different from `prev_pc` to catch an EPC taken from the wrong PC. It keeps non-zero `mem_rdata` during faults to catch load data that leaks through.

// File: rtl/tfu_pkg.sv
package tfu_pkg;

  localparam int VA_W    = 32;
  localparam int PG_BITS = 12;
  localparam int PPN_W   = VA_W - PG_BITS;
  localparam int OFF_W   = 12;
  localparam int CAUSE_W = 5;

  localparam logic [CAUSE_W-1:0] CAUSE_NONE   = 5'd0;
  localparam logic [CAUSE_W-1:0] CAUSE_MODIFY = 5'd1;
  localparam logic [CAUSE_W-1:0] CAUSE_LOADF  = 5'd2;
  localparam logic [CAUSE_W-1:0] CAUSE_STOREF = 5'd3;

  localparam logic [1:0] KIND_STORE = 2'b01;

  typedef enum logic [2:0] {
    FK_NONE, FK_LD_REFILL, FK_LD_INVAL, FK_ST_REFILL, FK_ST_INVAL, FK_MODIFY
  } fault_e;

  typedef struct packed {
    logic               exc;
    logic [CAUSE_W-1:0] cause;
    logic [OFF_W-1:0]   off;
    logic [VA_W-1:0]    target;
    logic [VA_W-1:0]    pa;
    logic               rd;
    logic               wr;
    logic               badv_we;
    logic [VA_W-1:0]    badv;
    logic               ctx_we;
    logic [VA_W-1:0]    ctx;
    logic               ehi_we;
    logic [VA_W-1:0]    ehi;
    logic               epc_we;
    logic [VA_W-1:0]    epc;
  } outcome_t;

  // Context: keep the upper base bits, drop the virtual page number into 22:4.
  function automatic logic [VA_W-1:0] ctx_merge(logic [VA_W-1:0] old, logic [VA_W-1:0] va);
    return {old[31:23], va[31:13], 4'b0000};
  endfunction

  // EntryHi: new virtual page number on top, address-space id kept.
  function automatic logic [VA_W-1:0] ehi_merge(logic [VA_W-1:0] old, logic [VA_W-1:0] va);
    return {va[31:13], 5'b00000, old[7:0]};
  endfunction

  function automatic logic is_refill(fault_e f);
    return (f == FK_LD_REFILL) || (f == FK_ST_REFILL);
  endfunction

  function automatic logic [CAUSE_W-1:0] cause_of(fault_e f);
    case (f)
      FK_LD_REFILL, FK_LD_INVAL: return CAUSE_LOADF;
      FK_ST_REFILL, FK_ST_INVAL: return CAUSE_STOREF;
      FK_MODIFY:                 return CAUSE_MODIFY;
      default:                   return CAUSE_NONE;
    endcase
  endfunction

endpackage

// File: rtl/tfu_classify.sv
module tfu_classify
  import tfu_pkg::*;
(
  input  logic [1:0] kind,
  input  logic       rd_ok,
  input  logic       wr_ok,
  input  logic       fixed,
  output fault_e     fault
);
  logic is_store;
  assign is_store = (kind == KIND_STORE);

  always_comb begin
    fault = FK_NONE;
    if (is_store) begin
      if (!wr_ok) begin
        if (rd_ok)      fault = FK_MODIFY;
        else if (fixed) fault = FK_ST_INVAL;
        else            fault = FK_ST_REFILL;
      end
    end else if (!rd_ok) begin
      fault = fixed ? FK_LD_INVAL : FK_LD_REFILL;
    end
  end
endmodule

// File: rtl/tfu_regcalc.sv
module tfu_regcalc
  import tfu_pkg::*;
#(
  parameter logic [VA_W-1:0]  VEC_BASE    = 32'h8000_0000,
  parameter logic [OFF_W-1:0] OFF_REFILL  = 12'h000,
  parameter logic [OFF_W-1:0] OFF_GENERAL = 12'h180
) (
  input  fault_e           fault,
  input  logic [1:0]       kind,
  input  logic [VA_W-1:0]  vaddr,
  input  logic [PPN_W-1:0] ppn,
  input  logic [VA_W-1:0]  prev_pc,
  input  logic [VA_W-1:0]  ctx_in,
  input  logic [VA_W-1:0]  ehi_in,
  output outcome_t         res
);
  logic faulted, tlb_miss;
  logic [OFF_W-1:0] off;
  assign faulted  = (fault != FK_NONE);
  assign tlb_miss = faulted && (fault != FK_MODIFY);
  assign off      = is_refill(fault) ? OFF_REFILL : OFF_GENERAL;

  always_comb begin
    res = '0;
    if (faulted) begin
      res.exc     = 1'b1;
      res.cause   = cause_of(fault);
      res.off     = off;
      res.target  = VEC_BASE + {{(VA_W-OFF_W){1'b0}}, off};
      res.badv_we = 1'b1;
      res.badv    = vaddr;
      res.epc_we  = 1'b1;
      res.epc     = prev_pc;
      res.ctx_we  = tlb_miss;
      res.ctx     = tlb_miss ? ctx_merge(ctx_in, vaddr) : '0;
      res.ehi_we  = tlb_miss;
      res.ehi     = tlb_miss ? ehi_merge(ehi_in, vaddr) : '0;
    end else begin
      res.pa = {ppn, vaddr[PG_BITS-1:0]};
      res.wr = (kind == KIND_STORE);
      res.rd = (kind != KIND_STORE);
    end
  end
endmodule

// File: rtl/tfu_stage.sv
module tfu_stage
  import tfu_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     valid,
  input  outcome_t nxt,
  output logic     vld_q,
  output outcome_t res_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= valid;
      res_q <= valid ? nxt : '0;
    end
  end
endmodule

// File: rtl/tfu_fault_unit.sv
module tfu_fault_unit
  import tfu_pkg::*;
#(
  parameter logic [31:0] VEC_BASE    = 32'h8000_0000,
  parameter logic [11:0] OFF_REFILL  = 12'h000,
  parameter logic [11:0] OFF_GENERAL = 12'h180
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_valid,
  input  logic [1:0]  acc_kind,
  input  logic [31:0] vaddr,
  input  logic [31:0] cur_pc,
  input  logic [31:0] prev_pc,
  input  logic [19:0] ent_ppn,
  input  logic        ent_rd,
  input  logic        ent_wr,
  input  logic        ent_fix,
  input  logic [31:0] ctx_in,
  input  logic [31:0] ehi_in,
  input  logic [31:0] mem_rdata,
  output logic        rsp_valid,
  output logic [31:0] pa,
  output logic        mem_rd,
  output logic        mem_wr,
  output logic [31:0] ld_data,
  output logic        exc,
  output logic [4:0]  cause,
  output logic [11:0] vec_off,
  output logic [31:0] target_pc,
  output logic        badv_we,
  output logic [31:0] badv,
  output logic        ctx_we,
  output logic [31:0] ctx,
  output logic        ehi_we,
  output logic [31:0] ehi,
  output logic        epc_we,
  output logic [31:0] epc
);
  fault_e   fault_kind;
  outcome_t next_res, res_q;
  logic     unused_pc;

  // The faulting instruction's own PC is never recorded: EPC uses the backed-up PC.
  assign unused_pc = ^cur_pc;

  tfu_classify u_cls (
    .kind(acc_kind), .rd_ok(ent_rd), .wr_ok(ent_wr), .fixed(ent_fix), .fault(fault_kind)
  );

  tfu_regcalc #(
    .VEC_BASE(VEC_BASE), .OFF_REFILL(OFF_REFILL), .OFF_GENERAL(OFF_GENERAL)
  ) u_calc (
    .fault(fault_kind), .kind(acc_kind), .vaddr(vaddr), .ppn(ent_ppn),
    .prev_pc(prev_pc), .ctx_in(ctx_in), .ehi_in(ehi_in), .res(next_res)
  );

  tfu_stage u_stg (
    .clk(clk), .rst_n(rst_n), .valid(acc_valid), .nxt(next_res),
    .vld_q(rsp_valid), .res_q(res_q)
  );

  assign pa        = res_q.pa;
  assign mem_rd    = res_q.rd;
  assign mem_wr    = res_q.wr;
  assign ld_data   = res_q.rd ? mem_rdata : '0;
  assign exc       = res_q.exc;
  assign cause     = res_q.cause;
  assign vec_off   = res_q.off;
  assign target_pc = res_q.target;
  assign badv_we   = res_q.badv_we;
  assign badv      = res_q.badv;
  assign ctx_we    = res_q.ctx_we;
  assign ctx       = res_q.ctx;
  assign ehi_we    = res_q.ehi_we;
  assign ehi       = res_q.ehi;
  assign epc_we    = res_q.epc_we;
  assign epc       = res_q.epc;
endmodule

// File: rtl/tfu_checker.sv
module tfu_checker
  import tfu_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        acc_valid,
  input logic [31:0] vaddr,
  input logic [31:0] prev_pc,
  input logic [31:0] ctx_in,
  input fault_e      fault_kind,
  input logic        rsp_valid,
  input logic        mem_rd,
  input logic        mem_wr,
  input logic [31:0] ld_data,
  input logic        exc,
  input logic [4:0]  cause,
  input logic [11:0] vec_off,
  input logic        badv_we,
  input logic [31:0] badv,
  input logic        ctx_we,
  input logic [31:0] ctx,
  input logic        ehi_we,
  input logic        epc_we,
  input logic [31:0] epc
);
  // R9: a fault suppresses both strobes and zeroes load data
  p_fault_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    exc |-> (!mem_rd && !mem_wr && ld_data == 32'h0));

  // R10: nothing comes out without a request in the previous cycle
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(acc_valid) |-> (!rsp_valid && !exc && !badv_we && !epc_we));

  // R5: BadVAddr captures the faulting address
  p_badv_r5: assert property (@(posedge clk) disable iff (!rst_n)
    exc |-> (badv_we && badv == $past(vaddr)));

  // R6: a modify fault keeps Context and EntryHi untouched
  p_modify_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (exc && cause == 5'd1) |-> (!ctx_we && !ehi_we));

  // R6: other faults carry the old Context base
  p_ctx_base_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (exc && cause != 5'd1) |-> (ctx_we && ctx[31:23] == $past(ctx_in[31:23])));

  // R8: EPC is the backed-up PC
  p_epc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    exc |-> (epc_we && epc == $past(prev_pc)));

  // R2: offset zero only for refill faults, which use load/store causes
  p_refill_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (exc && vec_off == 12'h000) |-> (cause == 5'd2 || cause == 5'd3));

  // R1: a classified fault in a request cycle shows as an exception next cycle
  p_fault_seen_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && fault_kind != FK_NONE) |=> exc);
endmodule

bind tfu_fault_unit tfu_checker u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .vaddr(vaddr), .prev_pc(prev_pc),
  .ctx_in(ctx_in), .fault_kind(fault_kind), .rsp_valid(rsp_valid), .mem_rd(mem_rd),
  .mem_wr(mem_wr), .ld_data(ld_data), .exc(exc), .cause(cause), .vec_off(vec_off),
  .badv_we(badv_we), .badv(badv), .ctx_we(ctx_we), .ctx(ctx), .ehi_we(ehi_we),
  .epc_we(epc_we), .epc(epc)
);

// File: tb/tfu_fault_unit_tb_top.sv
module tfu_fault_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h8000_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic acc_valid = 1'b0;
  logic [1:0] acc_kind = '0;
  logic [31:0] vaddr = '0, cur_pc = '0, prev_pc = '0, ctx_in = '0, ehi_in = '0, mem_rdata = '0;
  logic [19:0] ent_ppn = '0;
  logic ent_rd = 0, ent_wr = 0, ent_fix = 0;
  logic rsp_valid, mem_rd, mem_wr, exc, badv_we, ctx_we, ehi_we, epc_we;
  logic [31:0] pa, ld_data, target_pc, badv, ctx, ehi, epc;
  logic [4:0] cause;
  logic [11:0] vec_off;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tfu_fault_unit dut_i (.*);

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // Reference: 0 none, 1 modify, 2 load-fault, 3 store-fault; refill flag separate.
  function automatic logic [4:0] ref_cause(logic [1:0] k, logic r, logic w, logic f);
    if (k == 2'b01) return w ? 5'd0 : (r ? 5'd1 : 5'd3);
    return r ? 5'd0 : 5'd2;
  endfunction

  function automatic logic [11:0] ref_off(logic [1:0] k, logic r, logic w, logic f);
    logic [4:0] c = ref_cause(k, r, w, f);
    if (c == 5'd0) return 12'h000;
    if (c == 5'd1) return 12'h180;
    return f ? 12'h180 : 12'h000;
  endfunction

  task automatic access(logic [1:0] k, logic r, logic w, logic f, logic [31:0] va,
                        logic [19:0] ppn, string tag);
    logic [4:0] ec;
    logic [11:0] eo;
    logic [31:0] cx, eh, pp, rdat;
    cx = $urandom; eh = $urandom; pp = $urandom; rdat = $urandom | 32'h1;
    @(negedge clk);
    acc_valid = 1; acc_kind = k; ent_rd = r; ent_wr = w; ent_fix = f;
    vaddr = va; ent_ppn = ppn; ctx_in = cx; ehi_in = eh; prev_pc = pp;
    cur_pc = pp ^ 32'h0000_0ff4; mem_rdata = rdat;
    ec = ref_cause(k, r, w, f);
    eo = ref_off(k, r, w, f);
    @(negedge clk);
    acc_valid = 0;
    chk("R1", {tag, " rsp_valid"}, {31'b0, rsp_valid}, 32'd1);
    chk(k == 2'b10 ? "R11" : (k == 2'b01 ? "R3" : "R2"), {tag, " cause"}, {27'b0, cause}, {27'b0, ec});
    chk(k == 2'b01 ? "R3" : "R2", {tag, " vec_off"}, {20'b0, vec_off}, {20'b0, eo});
    chk("R4", {tag, " target_pc"}, target_pc, (ec != 0) ? BASE + {20'b0, eo} : 32'h0);
    if (ec == 0) begin
      chk("R1", {tag, " exc"}, {31'b0, exc}, 32'd0);
      chk("R1", {tag, " pa"}, pa, {ppn, va[11:0]});
      chk("R1", {tag, " mem_rd"}, {31'b0, mem_rd}, {31'b0, k != 2'b01});
      chk("R1", {tag, " mem_wr"}, {31'b0, mem_wr}, {31'b0, k == 2'b01});
      chk("R9", {tag, " ld_data pass"}, ld_data, (k != 2'b01) ? rdat : 32'h0);
    end else begin
      chk("R9", {tag, " exc"}, {31'b0, exc}, 32'd1);
      chk("R9", {tag, " strobes"}, {30'b0, mem_rd, mem_wr}, 32'd0);
      chk("R9", {tag, " pa"}, pa, 32'h0);
      chk("R9", {tag, " ld_data"}, ld_data, 32'h0);
      chk("R5", {tag, " badv"}, {badv_we ? badv : 32'hdead_beef}, va);
      chk("R8", {tag, " epc"}, {epc_we ? epc : 32'hdead_beef}, pp);
      chk("R6", {tag, " ctx_we"}, {31'b0, ctx_we}, {31'b0, ec != 5'd1});
      chk("R7", {tag, " ehi_we"}, {31'b0, ehi_we}, {31'b0, ec != 5'd1});
      if (ec != 5'd1) begin
        chk("R6", {tag, " ctx"}, ctx, (cx & 32'hff80_0000) | ((va >> 9) & 32'h007f_fff0));
        chk("R7", {tag, " ehi"}, ehi, (va & 32'hffff_e000) | (eh & 32'h0000_00ff));
      end
    end
  endtask

  task automatic idle_check();
    @(negedge clk);
    mem_rdata = 32'hffff_ffff;
    #1;
    chk("R10", "idle rsp_valid", {31'b0, rsp_valid}, 32'd0);
    chk("R10", "idle exc/we", {27'b0, exc, badv_we, ctx_we, ehi_we, epc_we}, 32'd0);
    chk("R10", "idle strobes", {30'b0, mem_rd, mem_wr}, 32'd0);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk("R10", "reset rsp_valid", {31'b0, rsp_valid}, 32'd0);
    chk("R10", "reset exc", {31'b0, exc}, 32'd0);
    rst_n = 1;
    idle_check();
    // Directed corners
    access(2'b01, 1, 0, 1, 32'h1234_5678, 20'habcde, "store ro fixed (modify wins)");
    access(2'b01, 0, 0, 1, 32'hfedc_b000, 20'h00001, "store invalid");
    access(2'b01, 0, 0, 0, 32'h0000_2fff, 20'h00002, "store refill");
    access(2'b00, 0, 1, 1, 32'h7fff_e004, 20'h00003, "load invalid");
    access(2'b00, 0, 1, 0, 32'h8000_1ffc, 20'h00004, "load refill");
    access(2'b10, 0, 0, 0, 32'h8000_1ffc, 20'h00005, "fetch refill");
    access(2'b10, 0, 0, 1, 32'hbfc0_0180, 20'h00006, "fetch invalid");
    access(2'b10, 1, 0, 0, 32'hbfc0_0180, 20'hfffff, "fetch ok");
    access(2'b01, 1, 1, 0, 32'hffff_ffff, 20'h54321, "store ok");
    access(2'b00, 1, 0, 1, 32'h0000_0000, 20'h00000, "load ok");
    idle_check();
    for (int i = 0; i < 400; i++) begin
      logic [3:0] rb;
      rb = 4'($urandom);
      access(rb[1:0], rb[2], rb[3], 1'($urandom), $urandom, 20'($urandom), "random");
      if ((i % 37) == 0) idle_check();
    end
    idle_check();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule